// File: doc/BRIEF.md
# Host Access Port and Control Register for a Time Slot Switch

This block is the host side of a time slot interchange switch. A host processor reaches it over a non-multiplexed bus: 8-bit data, six address lines, active-low chip select and data strobe, a read/write select and an active-low acknowledge. The block holds one 8-bit control register. It turns every other access into a single request to one of the switch core's three memories: the per-channel control memory, the per-channel source/data memory, or the received data memory.

The switch core reads and writes these memories for its serial traffic. It leaves one free memory cycle in each channel period and marks that cycle on `slot_free_i`. The port waits for that cycle, issues its request and captures the read data one cycle later. Only after that does it drive acknowledge low. So the acknowledge delay of a memory access depends on where in the channel period the access arrives. Control register accesses never wait. The control register picks the target memory and the stream half of the memory address. It also carries a split mode and the processor-enable bit that goes to the core.

Top module: `tsi_host_port`

## Requirements
- R1: After reset the control register reads 0x00, `ack_no` is high and `proc_en_o` is low.
- R2: An access with A5=0 and A1:A0=00 reaches the control register, and all 8 bits can be written and read. Read data is presented on `rdata_o` while `ack_no` is low and is 0 otherwise. Control bit 6 drives `proc_en_o`.
- R3: An access with A5=1 addresses memory location {control bits 2:0, A4..A0}. With control bits 4:3 = 10, it writes and reads the source/data memory (`mem_sel_o` = 10).
- R4: With control bits 4:3 = 11, accesses write and read the per-channel control memory (`mem_sel_o` = 11), and the source/data memory is left unchanged.
- R5: With control bits 4:3 = 01, reads return the received data memory (`mem_sel_o` = 01). Writes there are acknowledged but issue no memory request.
- R6: When control bit 7 (split) is set, memory reads go to the received data memory and memory writes go to the source/data memory, whatever bits 4:3 hold.
- R7: Control bits 2:0 select the stream. The same channel address under two stream values reaches two separate locations.
- R8: A memory request is only raised in a cycle where `slot_free_i` is high, and one access raises at most one request. A memory access is acknowledged between 3 and SLOT_PERIOD+2 cycles after the strobe is seen.
- R9: Acknowledge stays low until chip select or data strobe is released. It is high in the cycle after either goes high.
- R10: A control register access is acknowledged one cycle after the strobe is seen and raises no memory request.
- R11: An access with A5=0 and A1:A0 not 00, or a memory access while control bits 4:3 = 00 and split is clear, is acknowledged. It reads 0, raises no memory request and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| ds_ni | input | 1 | Data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 6 | Host address A5..A0 |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid while ack_no is low |
| ack_no | output | 1 | Data acknowledge, active low |
| slot_free_i | input | 1 | Core marks the free memory cycle of the channel period |
| mem_req_o | output | 1 | Memory request to the core |
| mem_we_o | output | 1 | Write qualifier for mem_req_o |
| mem_sel_o | output | 2 | Target memory: 01 received data, 10 source/data, 11 control |
| mem_addr_o | output | 8 | Memory address {stream, channel} |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after a request |
| proc_en_o | output | 1 | Processor-enable bit to the core |

## Verification
Memory accesses are started at several offsets inside the free-slot period. The spread of acknowledge delays shows that grants wait for the free cycle and are not issued at once. Writes and read-backs to the same channel under different memory selects and stream values show whether the address and target are built from the control register or from stale values. Split mode is checked with a select value that points somewhere else, so a decoder that ignores split is caught. Unmapped addresses and writes to read-only memory are followed by read-backs and request counts, so an access that leaks through is caught.

// File: rtl/tsi_port_pkg.sv
package tsi_port_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_DM   = 2'b01,
    SEL_CML  = 2'b10,
    SEL_CMH  = 2'b11
  } mem_sel_e;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_CTRL = 2'd1,
    K_MEM  = 2'd2
  } acc_kind_e;

  localparam int CR_SPLIT   = 7;
  localparam int CR_PE      = 6;
  localparam int CR_SEL_LSB = 3;
endpackage

// File: rtl/tsi_port_decode.sv
module tsi_port_decode
  import tsi_port_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              split_i,
  input  mem_sel_e          sel_cfg_i,
  output acc_kind_e         kind_o,
  output mem_sel_e          tgt_o
);
  always_comb begin
    tgt_o  = SEL_NONE;
    kind_o = K_NONE;
    if (!addr_i[ADDR_W-1]) begin
      if (addr_i[1:0] == 2'b00) kind_o = K_CTRL;
    end else begin
      if (split_i) tgt_o = rd_i ? SEL_DM : SEL_CML;
      else         tgt_o = sel_cfg_i;
      // read-only memory: writes are dropped here
      if (tgt_o != SEL_NONE && !(tgt_o == SEL_DM && !rd_i)) kind_o = K_MEM;
    end
  end
endmodule

// File: rtl/tsi_port_ctrl_reg.sv
module tsi_port_ctrl_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/tsi_port_seq.sv
module tsi_port_seq
  import tsi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 5,
  parameter int STRM_W = 3,
  localparam int MADDR_W = STRM_W + CHAN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  acc_kind_e          kind_i,
  input  mem_sel_e           tgt_i,
  input  logic               rd_i,
  input  logic [CHAN_W-1:0]  chan_i,
  input  logic [STRM_W-1:0]  strm_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  ctrl_q_i,
  input  logic               slot_free_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               ctrl_we_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output mem_sel_e           mem_sel_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               ack_no
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CAPT, S_DONE} st_e;
  st_e st_q;
  logic              rd_q;
  logic [DATA_W-1:0] rdata_q;

  assign ctrl_we_o = (st_q == S_IDLE) && strobe_i && (kind_i == K_CTRL) && !rd_i;
  assign mem_req_o = (st_q == S_WAIT) && strobe_i && slot_free_i;
  assign mem_we_o  = mem_req_o && !rd_q;
  assign ack_no    = (st_q != S_DONE);
  assign rdata_o   = (st_q == S_DONE) ? rdata_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      rd_q        <= 1'b0;
      rdata_q     <= '0;
      mem_sel_o   <= SEL_NONE;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else if (!strobe_i) begin
      st_q <= S_IDLE;  // release or abort
    end else begin
      unique case (st_q)
        S_IDLE: begin
          rd_q        <= rd_i;
          mem_sel_o   <= tgt_i;
          mem_addr_o  <= {strm_i, chan_i};
          mem_wdata_o <= wdata_i;
          rdata_q     <= (kind_i == K_CTRL && rd_i) ? ctrl_q_i : '0;
          st_q        <= (kind_i == K_MEM) ? S_WAIT : S_DONE;
        end
        S_WAIT: if (slot_free_i) st_q <= S_CAPT;
        S_CAPT: begin
          if (rd_q) rdata_q <= mem_rdata_i;
          st_q <= S_DONE;
        end
        S_DONE: st_q <= S_DONE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsi_host_port.sv
module tsi_host_port
  import tsi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int STRM_W = 3,
  localparam int CHAN_W  = ADDR_W - 1,
  localparam int MADDR_W = STRM_W + CHAN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               ds_ni,
  input  logic               rw_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               ack_no,
  input  logic               slot_free_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [1:0]         mem_sel_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               proc_en_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic              ctrl_we;
  logic              strobe;
  acc_kind_e         kind;
  mem_sel_e          tgt, sel_cfg, sel_out;

  assign strobe    = !cs_ni && !ds_ni;
  assign sel_cfg   = mem_sel_e'(ctrl_q[CR_SEL_LSB +: 2]);
  assign proc_en_o = ctrl_q[CR_PE];
  assign mem_sel_o = sel_out;

  tsi_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .rd_i     (rw_i),
    .split_i  (ctrl_q[CR_SPLIT]),
    .sel_cfg_i(sel_cfg),
    .kind_o   (kind),
    .tgt_o    (tgt)
  );

  tsi_port_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_we),
    .wdata_i(wdata_i),
    .q_o    (ctrl_q)
  );

  tsi_port_seq #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .STRM_W(STRM_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe),
    .kind_i     (kind),
    .tgt_i      (tgt),
    .rd_i       (rw_i),
    .chan_i     (addr_i[CHAN_W-1:0]),
    .strm_i     (ctrl_q[STRM_W-1:0]),
    .wdata_i    (wdata_i),
    .ctrl_q_i   (ctrl_q),
    .slot_free_i(slot_free_i),
    .mem_rdata_i(mem_rdata_i),
    .ctrl_we_o  (ctrl_we),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_sel_o  (sel_out),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .rdata_o    (rdata_o),
    .ack_no     (ack_no)
  );
endmodule

// File: rtl/tsi_host_port_chk.sv
module tsi_host_port_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              ds_ni,
  input logic              rw_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              slot_free_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [1:0]        mem_sel_o,
  input logic              ack_no,
  input logic              proc_en_o
);
  // R8: grants only in the free memory cycle
  a_r8_req_in_free_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> slot_free_i);
  // R8: one request per access
  a_r8_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R5: no writes reach the received data memory
  a_r5_no_dm_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_sel_o != 2'b01);
  // R9: acknowledge released after strobe release
  a_r9_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || ds_ni) |=> ack_no);
  // R2: processor enable only moves on a control register write
  a_r2_pe_on_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(proc_en_o) |->
      $past(!cs_ni && !ds_ni && !rw_i && !addr_i[ADDR_W-1] && addr_i[1:0] == 2'b00));
endmodule

bind tsi_host_port tsi_host_port_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tsi_host_port_tb.sv
module tsi_host_port_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int SLOT_PERIOD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       ack_n, slot_free = 1'b0;
  logic       mem_req, mem_we, proc_en;
  logic [1:0] mem_sel;
  logic [7:0] mem_addr, mem_wdata, mem_rdata = '0;

  int errors = 0, checks = 0;
  int req_cnt = 0, bad_req = 0, dm_we_cnt = 0;
  bit done = 0;

  logic [7:0] dm [256];
  logic [7:0] cml[256];
  logic [7:0] cmh[256];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsi_host_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ds_ni(ds_n), .rw_i(rw),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_no(ack_n),
    .slot_free_i(slot_free), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_sel_o(mem_sel), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .proc_en_o(proc_en)
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % SLOT_PERIOD;
      slot_free = (ph == SLOT_PERIOD - 1);
    end
  end

  // memory model of the switch core
  always @(posedge clk) begin
    if (mem_req) begin
      req_cnt <= req_cnt + 1;
      if (!slot_free) bad_req <= bad_req + 1;
      case (mem_sel)
        2'b01: mem_rdata <= dm[mem_addr];
        2'b10: mem_rdata <= cml[mem_addr];
        2'b11: mem_rdata <= cmh[mem_addr];
        default: mem_rdata <= 8'h00;
      endcase
      if (mem_we) begin
        case (mem_sel)
          2'b01: begin dm[mem_addr] <= mem_wdata; dm_we_cnt <= dm_we_cnt + 1; end
          2'b10: cml[mem_addr] <= mem_wdata;
          2'b11: cmh[mem_addr] <= mem_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic rd, input logic [5:0] a, input logic [7:0] wd,
                     output logic [7:0] rv, output int lat);
    @(negedge clk);
    cs_n = 1'b0; ds_n = 1'b0; rw = rd; addr = a; wdata = wd; lat = 0;
    do begin @(negedge clk); lat++; end while (ack_n && lat < 50);
    rv = rdata;
    cs_n = 1'b1; ds_n = 1'b1; rw = 1'b1;
    @(negedge clk);
    chk(ack_n === 1'b1, "R9 ack released", int'(ack_n), 1);
    chk(rdata === 8'h00, "R2 rdata idle zero", int'(rdata), 0);
  endtask

  task automatic ctrl_wr(input logic [7:0] v);
    logic [7:0] rv; int lat;
    bus(1'b0, 6'h00, v, rv, lat);
  endtask

  task automatic mem_wr(input logic [4:0] ch, input logic [7:0] v, output int lat);
    logic [7:0] rv;
    bus(1'b0, {1'b1, ch}, v, rv, lat);
  endtask

  task automatic mem_rd(input logic [4:0] ch, output logic [7:0] rv);
    int lat;
    bus(1'b1, {1'b1, ch}, 8'h00, rv, lat);
  endtask

  task automatic t_reset();
    logic [7:0] rv; int lat;
    chk(ack_n === 1'b1, "R1 ack after reset", int'(ack_n), 1);
    chk(proc_en === 1'b0, "R1 proc_en after reset", int'(proc_en), 0);
    bus(1'b1, 6'h00, 8'h00, rv, lat);
    chk(rv === 8'h00, "R1 ctrl reset value", int'(rv), 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] rv; int lat, r0;
    r0 = req_cnt;
    bus(1'b0, 6'h00, 8'h6B, rv, lat);
    chk(lat == 1, "R10 ctrl write latency", lat, 1);
    chk(proc_en === 1'b1, "R2 proc_en set", int'(proc_en), 1);
    bus(1'b1, 6'h1C, 8'h00, rv, lat);  // A5=0, A1:A0=00
    chk(rv === 8'h6B, "R2 ctrl readback", int'(rv), 'h6B);
    chk(lat == 1, "R10 ctrl read latency", lat, 1);
    chk(req_cnt == r0, "R10 no memory request", req_cnt - r0, 0);
    ctrl_wr(8'h0B);
    chk(proc_en === 1'b0, "R2 proc_en cleared", int'(proc_en), 0);
  endtask

  task automatic t_unmapped();
    logic [7:0] rv; int lat, r0;
    r0 = req_cnt;
    bus(1'b0, 6'h02, 8'hFF, rv, lat);
    bus(1'b1, 6'h01, 8'h00, rv, lat);
    chk(rv === 8'h00, "R11 unmapped reads 0", int'(rv), 0);
    bus(1'b1, 6'h00, 8'h00, rv, lat);
    chk(rv === 8'h0B, "R11 ctrl untouched", int'(rv), 'h0B);
    ctrl_wr(8'h03);  // select 00
    bus(1'b0, 6'h25, 8'h99, rv, lat);
    bus(1'b1, 6'h25, 8'h00, rv, lat);
    chk(rv === 8'h00, "R11 select none reads 0", int'(rv), 0);
    chk(req_cnt == r0, "R11 no memory request", req_cnt - r0, 0);
  endtask

  task automatic t_cml_cmh();
    logic [7:0] rv; int lat;
    ctrl_wr(8'h13);  // CML, stream 3
    mem_wr(5'd7, 8'h3C, lat);
    chk(cml[8'h67] === 8'h3C, "R3 CML write location", int'(cml[8'h67]), 'h3C);
    mem_rd(5'd7, rv);
    chk(rv === 8'h3C, "R3 CML readback", int'(rv), 'h3C);
    ctrl_wr(8'h1B);  // CMH, stream 3
    mem_wr(5'd7, 8'hC3, lat);
    chk(cmh[8'h67] === 8'hC3, "R4 CMH write location", int'(cmh[8'h67]), 'hC3);
    chk(cml[8'h67] === 8'h3C, "R4 CML untouched", int'(cml[8'h67]), 'h3C);
    mem_rd(5'd7, rv);
    chk(rv === 8'hC3, "R4 CMH readback", int'(rv), 'hC3);
  endtask

  task automatic t_stream();
    logic [7:0] rv; int lat;
    ctrl_wr(8'h15);  // CML, stream 5
    mem_wr(5'd7, 8'h77, lat);
    chk(cml[8'hA7] === 8'h77, "R7 stream 5 location", int'(cml[8'hA7]), 'h77);
    chk(cml[8'h67] === 8'h3C, "R7 stream 3 untouched", int'(cml[8'h67]), 'h3C);
    ctrl_wr(8'h13);
    mem_rd(5'd7, rv);
    chk(rv === 8'h3C, "R7 stream 3 readback", int'(rv), 'h3C);
  endtask

  task automatic t_dm();
    logic [7:0] rv; int lat, w0;
    w0 = dm_we_cnt;
    ctrl_wr(8'h0A);  // DM, stream 2
    mem_rd(5'd9, rv);
    chk(rv === (8'h49 ^ 8'hA5), "R5 DM read", int'(rv), int'(8'h49 ^ 8'hA5));
    mem_wr(5'd9, 8'hFF, lat);
    chk(lat < 50, "R5 DM write acknowledged", lat, 1);
    chk(dm_we_cnt == w0, "R5 no DM write", dm_we_cnt - w0, 0);
    mem_rd(5'd9, rv);
    chk(rv === (8'h49 ^ 8'hA5), "R5 DM unchanged", int'(rv), int'(8'h49 ^ 8'hA5));
  endtask

  task automatic t_split();
    logic [7:0] rv; int lat;
    ctrl_wr(8'h99);  // split, select CMH, stream 1
    mem_wr(5'd4, 8'h5D, lat);
    chk(cml[8'h24] === 8'h5D, "R6 split write to CML", int'(cml[8'h24]), 'h5D);
    chk(cmh[8'h24] === 8'h00, "R6 CMH untouched", int'(cmh[8'h24]), 0);
    mem_rd(5'd4, rv);
    chk(rv === (8'h24 ^ 8'hA5), "R6 split read from DM", int'(rv), int'(8'h24 ^ 8'hA5));
  endtask

  task automatic t_contention();
    logic [7:0] rv; int lat, lmin, lmax;
    lmin = 1000; lmax = 0;
    ctrl_wr(8'h13);
    for (int i = 0; i < SLOT_PERIOD; i++) begin
      repeat (i) @(negedge clk);
      bus(1'b1, 6'h27, 8'h00, rv, lat);
      chk(lat >= 3 && lat <= SLOT_PERIOD + 2, "R8 ack latency bound", lat, SLOT_PERIOD + 2);
      chk(rv === 8'h3C, "R8 read under contention", int'(rv), 'h3C);
      if (lat < lmin) lmin = lat;
      if (lat > lmax) lmax = lat;
    end
    chk(lmax > lmin, "R8 latency varies with slot phase", lmax - lmin, 1);
    chk(bad_req == 0, "R8 request outside free slot", bad_req, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      dm[i] = 8'(i) ^ 8'hA5; cml[i] = 8'h00; cmh[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_unmapped();
    t_cml_cmh();
    t_stream();
    t_dm();
    t_split();
    t_contention();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule